// File: doc/BRIEF.md
# Multi-Mode PRG Bank Mapper

This block turns a CPU address in the 0x6000–0xFFFF range into an address in program ROM. Four 6-bit bank registers and two control registers decide the mapping. A mode field picks the page size: one 32K page, two 16K pages, four 8K pages, or four 8K pages whose bank numbers are bit-permuted first. A control bit makes the top slot either follow bank register 3 or stay fixed at 0x3F. A second control bit opens an 8K ROM window at 0x6000–0x7FFF. The bank for that window is derived from bank register 3 in a way that depends on the mode. An outer-bank field is ORed in at bit 5 of the 8K bank number, which lets one large ROM hold several independent images.

The translation path is purely combinational from the held registers and the CPU address. Register writes take effect at the next rising clock edge. When the window is closed, the block raises an open-bus flag for reads in 0x6000–0x7FFF and supplies the upper address byte as the value the CPU would see.

Top module: `prg_bank_mapper`

## Requirements
- R1: When `rom_sel` is high, `rom_addr` is the 8K bank number concatenated with `cpu_addr[12:0]`. `rom_sel` is high for every address with bit 15 set, and for 0x6000–0x7FFF when the window is open.
- R2: A write with `wr_addr[15:12]` = 0x8 stores `wr_data[5:0]` into bank register `wr_addr[1:0]`. Data bits 7:6 are discarded.
- R3: After reset, all four bank registers hold 0x3F and both control registers hold 0. In this state, reading 0x8000 maps to 8K bank 0x3C and reading 0x6000 is open bus.
- R4: With mode 0 (32K), the 8K bank is `{last[3:0], cpu_addr[14:13]}`.
- R5: With mode 1 (16K), 0x8000–0xBFFF uses `{reg1[4:0], cpu_addr[13]}` and 0xC000–0xFFFF uses `{last[4:0], cpu_addr[13]}`.
- R6: With mode 2 (8K), slots 0x8000, 0xA000 and 0xC000 use bank registers 0, 1 and 2. Slot 0xE000 uses the last value.
- R7: With mode 3 (reversed 8K), each 8K bank number is permuted first. Result bits 5, 4, 2 and 1 take source bits 1, 2, 4 and 5. Result bits 3 and 0 are zero.
- R8: Control bit 2 set makes the last value bank register 3. When the bit is clear, the last value is 0x3F.
- R9: With control bit 7 set, 0x6000–0x7FFF maps to a bank derived from register 3. In 32K mode the bank is `{reg3[3:0],2'b11}`, in 16K mode `{reg3[4:0],1'b1}`, in 8K mode `reg3`, and in reversed mode the permuted `reg3`.
- R10: With control bit 7 clear, reads in 0x6000–0x7FFF raise `open_bus`, keep `rom_sel` low and present `cpu_addr[15:8]` on `bus_byte`.
- R11: The outer register's low OUTER_W bits are ORed into the 8K bank number starting at bit 5, in every mode and in the window.
- R12: Addresses below 0x6000 raise neither `rom_sel` nor `open_bus`.
- R13: The mode/control register is written in 0xD000–0xDFFF when `wr_addr[1:0]` = 0, and the outer register when `wr_addr[1:0]` = 3. Mode is control bits 1:0, with 0 = 32K, 1 = 16K, 2 = 8K and 3 = reversed. A write changes the mapping only after the clock edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | CPU address of the write |
| wr_data | input | 8 | Write data |
| cpu_addr | input | 16 | CPU address to translate |
| rom_addr | output | ROM_AW (21) | Translated program ROM byte address |
| rom_sel | output | 1 | ROM is the target of this address |
| open_bus | output | 1 | Read falls in the closed 0x6000 window |
| bus_byte | output | 8 | Open-bus value (upper address byte) |

## Verification
A bank-register write and a translation of the slot that register controls can happen in the same cycle. This is the case the bench provokes directly. It holds `cpu_addr` on the 8K slot at 0x8000 while it presents a write to bank register 0. It then samples `rom_addr` twice: just before the storing edge, where the old bank is expected, and after the edge, where the new bank is expected. The same before/after reasoning covers control writes that switch the mode while an address is held. For this reason every table entry is sampled a full cycle after its control writes.

// File: rtl/prg_map_pkg.sv
// Shared definitions for the PRG bank mapper: mode encoding and the
// bank-number permutation used by the reversed 8K mode.
// Assumes bank registers are 6 bits wide.
package prg_map_pkg;

    localparam int BANK_REG_W = 6;

    typedef enum logic [1:0] {
        PM_32K     = 2'd0,
        PM_16K     = 2'd1,
        PM_8K      = 2'd2,
        PM_8K_REV  = 2'd3
    } prg_mode_e;

    // Permute a 6-bit bank number; bits 3 and 0 of the result are zero.
    function automatic logic [BANK_REG_W-1:0] bank_permute(input logic [BANK_REG_W-1:0] v);
        return {v[1], v[2], 1'b0, v[4], v[5], 1'b0};
    endfunction

endpackage

// File: rtl/prg_bank_regs.sv
// Register file of the PRG mapper: four 6-bit bank registers, the
// mode/control register and the outer-bank register.
// Assumes writes are decoded from the upper nibble and low two address bits.
module prg_bank_regs #(
    parameter int NUM_BANKS = 4,
    parameter int OUTER_W   = 3
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [15:0]                            wr_addr,
    input  logic [7:0]                             wr_data,
    output logic [NUM_BANKS-1:0][prg_map_pkg::BANK_REG_W-1:0] bank_q,
    output logic [7:0]                             ctrl_q,
    output logic [OUTER_W-1:0]                     outer_q
);
    import prg_map_pkg::*;

    localparam int IDX_W = $clog2(NUM_BANKS);

    logic bank_region;
    logic cfg_region;

    // Decode the two write regions.
    always_comb begin
        bank_region = wr_en && (wr_addr[15:12] == 4'h8);
        cfg_region  = wr_en && (wr_addr[15:12] == 4'hD);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // Hold one bank register; reset to the all-ones bank.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[b] <= '1;
            else if (bank_region && (wr_addr[IDX_W-1:0] == IDX_W'(b)))
                bank_q[b] <= wr_data[BANK_REG_W-1:0];
        end
    end

    // Hold the mode/control and outer-bank registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            outer_q <= '0;
        end else if (cfg_region) begin
            if (wr_addr[1:0] == 2'd0)
                ctrl_q <= wr_data;
            if (wr_addr[1:0] == 2'd3)
                outer_q <= wr_data[OUTER_W-1:0];
        end
    end

endmodule

// File: rtl/prg_slot_calc.sv
// Combinational translation of a CPU address into an 8K bank number.
// Handles the four page modes, the 0x6000 window and the outer field.
// Assumes four bank registers and OUTER_W of at least 1.
module prg_slot_calc #(
    parameter int OUTER_W = 3,
    parameter int BANK_W  = OUTER_W + 5
) (
    input  logic [3:0][prg_map_pkg::BANK_REG_W-1:0] bank_q,
    input  logic [7:0]                              ctrl_q,
    input  logic [OUTER_W-1:0]                      outer_q,
    input  logic [15:0]                             cpu_addr,
    output logic [BANK_W-1:0]                       bank8k,
    output logic                                    rom_sel,
    output logic                                    open_bus
);
    import prg_map_pkg::*;

    prg_mode_e               mode;
    logic                    last_prog;
    logic                    win_en;
    logic [BANK_REG_W-1:0]   last_bank;
    logic [1:0]              slot;
    logic [3:0][BANK_REG_W-1:0] plain_b;
    logic [3:0][BANK_REG_W-1:0] perm_b;
    logic [BANK_REG_W-1:0]   hi_base;
    logic [BANK_REG_W-1:0]   win_base;
    logic                    in_win;
    logic                    in_hi;

    // Unpack control fields and the top-slot bank.
    always_comb begin
        mode      = prg_mode_e'(ctrl_q[1:0]);
        last_prog = ctrl_q[2];
        win_en    = ctrl_q[7];
        last_bank = last_prog ? bank_q[3] : {BANK_REG_W{1'b1}};
        slot      = cpu_addr[14:13];
        in_win    = (cpu_addr[15:13] == 3'b011);
        in_hi     = cpu_addr[15];
    end

    for (genvar s = 0; s < 4; s++) begin : g_slot
        // Per-slot source bank, plain and permuted.
        if (s == 3) begin : g_top
            always_comb plain_b[s] = last_bank;
        end else begin : g_low
            always_comb plain_b[s] = bank_q[s];
        end
        always_comb perm_b[s] = bank_permute(plain_b[s]);
    end

    // Select the 8K bank for 0x8000-0xFFFF according to the mode.
    always_comb begin
        unique case (mode)
            PM_32K:    hi_base = {last_bank[3:0], slot};
            PM_16K:    hi_base = cpu_addr[14] ? {last_bank[4:0], cpu_addr[13]}
                                              : {bank_q[1][4:0], cpu_addr[13]};
            PM_8K:     hi_base = plain_b[slot];
            default:   hi_base = perm_b[slot];
        endcase
    end

    // Derive the 0x6000 window bank from register 3 according to the mode.
    always_comb begin
        unique case (mode)
            PM_32K:    win_base = {bank_q[3][3:0], 2'b11};
            PM_16K:    win_base = {bank_q[3][4:0], 1'b1};
            PM_8K:     win_base = bank_q[3];
            default:   win_base = bank_permute(bank_q[3]);
        endcase
    end

    // Merge the outer field and produce the region flags.
    always_comb begin
        bank8k   = BANK_W'(in_hi ? hi_base : win_base) | {outer_q, 5'b0};
        rom_sel  = in_hi || (in_win && win_en);
        open_bus = in_win && !win_en;
    end

endmodule

// File: rtl/prg_bank_mapper.sv
// Top of the PRG bank mapper: register file plus combinational translator.
// Assumes a single clock; register writes become visible after the edge.
module prg_bank_mapper #(
    parameter int OUTER_W = 3,
    parameter int BANK_W  = OUTER_W + 5,
    parameter int ROM_AW  = BANK_W + 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       cpu_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel,
    output logic              open_bus,
    output logic [7:0]        bus_byte
);
    import prg_map_pkg::*;

    logic [3:0][BANK_REG_W-1:0] bank_q;
    logic [7:0]                 ctrl_q;
    logic [OUTER_W-1:0]         outer_q;
    logic [BANK_W-1:0]          bank8k;

    prg_bank_regs #(
        .NUM_BANKS (4),
        .OUTER_W   (OUTER_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_q  (bank_q),
        .ctrl_q  (ctrl_q),
        .outer_q (outer_q)
    );

    prg_slot_calc #(
        .OUTER_W (OUTER_W),
        .BANK_W  (BANK_W)
    ) u_calc (
        .bank_q   (bank_q),
        .ctrl_q   (ctrl_q),
        .outer_q  (outer_q),
        .cpu_addr (cpu_addr),
        .bank8k   (bank8k),
        .rom_sel  (rom_sel),
        .open_bus (open_bus)
    );

    // Form the ROM byte address and the open-bus byte.
    always_comb begin
        rom_addr = {bank8k, cpu_addr[12:0]};
        bus_byte = cpu_addr[15:8];
    end

endmodule

// File: rtl/prg_bank_mapper_chk.sv
// Assertion checker for prg_bank_mapper, attached by bind below.
// Assumes OUTER_W of at least 2 so the upper outer bits are visible.
module prg_bank_mapper_chk #(
    parameter int OUTER_W = 3,
    parameter int ROM_AW  = OUTER_W + 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [15:0]       wr_addr,
    input logic [7:0]        wr_data,
    input logic [15:0]       cpu_addr,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              rom_sel,
    input logic              open_bus,
    input logic [7:0]        bus_byte,
    input logic [23:0]       bank_flat,
    input logic [7:0]        ctrl_q,
    input logic [OUTER_W-1:0] outer_q
);

    assert_bank_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'h8)
        |=> bank_flat[$past(wr_addr[1:0])*6 +: 6] == $past(wr_data[5:0]));

    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> rom_addr[12:0] == cpu_addr[12:0]);

    assert_page32_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && cpu_addr[15] && ctrl_q[1:0] == 2'd0)
        |-> rom_addr[14:13] == cpu_addr[14:13]);

    assert_page16_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sel && cpu_addr[15] && ctrl_q[1:0] == 2'd1)
        |-> rom_addr[13] == cpu_addr[13]);

    assert_open_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        open_bus |-> (!rom_sel && bus_byte == cpu_addr[15:8] && cpu_addr[15:13] == 3'b011));

    assert_outer_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> rom_addr[ROM_AW-1:19] == outer_q[OUTER_W-1:1]);

    assert_low_space_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr < 16'h6000) |-> (!rom_sel && !open_bus));

endmodule

bind prg_bank_mapper prg_bank_mapper_chk #(
    .OUTER_W (OUTER_W),
    .ROM_AW  (ROM_AW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cpu_addr  (cpu_addr),
    .rom_addr  (rom_addr),
    .rom_sel   (rom_sel),
    .open_bus  (open_bus),
    .bus_byte  (bus_byte),
    .bank_flat (bank_q),
    .ctrl_q    (ctrl_q),
    .outer_q   (outer_q)
);

// File: tb/prg_bank_mapper_tb.sv
module prg_bank_mapper_tb;

    localparam int OUTER_W = 3;
    localparam int ROM_AW  = OUTER_W + 18;

    typedef struct packed {
        logic [31:0] tag;
        logic [7:0]  ctrl;
        logic [7:0]  outer;
        logic [15:0] addr;
        logic        sel;
        logic        ob;
        logic [7:0]  bank;
    } vec_t;

    // Bank registers during the table: r0=0x05 r1=0x12 r2=0x2A r3=0x17.
    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{"R4",  8'h00, 8'h0, 16'hA123, 1'b1, 1'b0, 8'h3D},
        '{"R8",  8'h04, 8'h0, 16'hE000, 1'b1, 1'b0, 8'h1F},
        '{"R5",  8'h01, 8'h0, 16'h9000, 1'b1, 1'b0, 8'h24},
        '{"R5",  8'h01, 8'h0, 16'hE000, 1'b1, 1'b0, 8'h3F},
        '{"R8",  8'h05, 8'h0, 16'hC000, 1'b1, 1'b0, 8'h2E},
        '{"R6",  8'h02, 8'h0, 16'h8000, 1'b1, 1'b0, 8'h05},
        '{"R6",  8'h02, 8'h0, 16'hA000, 1'b1, 1'b0, 8'h12},
        '{"R6",  8'h02, 8'h0, 16'hC000, 1'b1, 1'b0, 8'h2A},
        '{"R6",  8'h02, 8'h0, 16'hE000, 1'b1, 1'b0, 8'h3F},
        '{"R8",  8'h06, 8'h0, 16'hE000, 1'b1, 1'b0, 8'h17},
        '{"R7",  8'h03, 8'h0, 16'h8000, 1'b1, 1'b0, 8'h10},
        '{"R7",  8'h03, 8'h0, 16'hC000, 1'b1, 1'b0, 8'h22},
        '{"R7",  8'h03, 8'h0, 16'hE000, 1'b1, 1'b0, 8'h36},
        '{"R7",  8'h07, 8'h0, 16'hA000, 1'b1, 1'b0, 8'h24},
        '{"R9",  8'h82, 8'h0, 16'h6000, 1'b1, 1'b0, 8'h17},
        '{"R9",  8'h80, 8'h0, 16'h7FFF, 1'b1, 1'b0, 8'h1F},
        '{"R9",  8'h81, 8'h0, 16'h6100, 1'b1, 1'b0, 8'h2F},
        '{"R9",  8'h83, 8'h0, 16'h7000, 1'b1, 1'b0, 8'h34},
        '{"R10", 8'h02, 8'h0, 16'h6ABC, 1'b0, 1'b1, 8'h00},
        '{"R12", 8'h82, 8'h0, 16'h4020, 1'b0, 1'b0, 8'h00},
        '{"R11", 8'h02, 8'h5, 16'h8000, 1'b1, 1'b0, 8'hA5},
        '{"R11", 8'h00, 8'h3, 16'hC000, 1'b1, 1'b0, 8'h7E}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [15:0]       cpu_addr = '0;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_sel;
    logic              open_bus;
    logic [7:0]        bus_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prg_bank_mapper #(.OUTER_W(OUTER_W)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cpu_addr (cpu_addr),
        .rom_addr (rom_addr),
        .rom_sel  (rom_sel),
        .open_bus (open_bus),
        .bus_byte (bus_byte)
    );

    task automatic check_eq(input string tag, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        cpu_addr = a;
        #1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: reset state, 32K mode with fixed top bank 0x3F.
        look(16'h8000);
        check_eq("R3", "reset 0x8000 addr", 32'(rom_addr), 32'({8'h3C, 13'h0}));
        look(16'h6000);
        check_eq("R3", "reset window open_bus", 32'(open_bus), 32'd1);

        // R2: load banks; upper data bits discarded, index from addr[1:0].
        reg_write(16'h8000, 8'hC5);
        reg_write(16'h8FF1, 8'h12);
        reg_write(16'h8002, 8'h6A);
        reg_write(16'h8003, 8'h57);
        reg_write(16'hD004, 8'h02);   // R13: mirrored control address
        look(16'h8000);
        check_eq("R2", "bank0 masked", 32'(rom_addr[20:13]), 32'h05);
        look(16'hC000);
        check_eq("R2", "bank2 masked", 32'(rom_addr[20:13]), 32'h2A);
        check_eq("R13", "mirror ctrl write gives 8K", 32'(rom_sel), 32'd1);

        // R13: write to 0xD001 must not disturb mode or outer bank.
        reg_write(16'hD001, 8'hFF);
        look(16'hA000);
        check_eq("R13", "ignored D001 write", 32'(rom_addr[20:13]), 32'h12);

        // Table walk across modes, window, open bus and outer field.
        for (int i = 0; i < NV; i++) begin
            reg_write(16'hD000, VECS[i].ctrl);
            reg_write(16'hD003, VECS[i].outer);
            look(VECS[i].addr);
            check_eq(string'(VECS[i].tag), "rom_sel", 32'(rom_sel), 32'(VECS[i].sel));
            check_eq(string'(VECS[i].tag), "open_bus", 32'(open_bus), 32'(VECS[i].ob));
            if (VECS[i].sel)
                check_eq(string'(VECS[i].tag), "rom_addr (R1)", 32'(rom_addr),
                         32'({VECS[i].bank, VECS[i].addr[12:0]}));
            if (VECS[i].ob)
                check_eq(string'(VECS[i].tag), "bus_byte", 32'(bus_byte),
                         32'(VECS[i].addr[15:8]));
        end

        // R11: outer field also applies to the window.
        reg_write(16'hD000, 8'h82);
        reg_write(16'hD003, 8'h07);
        look(16'h6010);
        check_eq("R11", "outer in window", 32'(rom_addr), 32'({8'hF7, 13'h0010}));

        // R13: same-cycle write and translation of bank register 0.
        reg_write(16'hD003, 8'h00);
        reg_write(16'hD000, 8'h02);
        look(16'h8000);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 16'h8000; wr_data = 8'h09;
        #3;
        check_eq("R13", "old bank before edge", 32'(rom_addr[20:13]), 32'h05);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check_eq("R13", "new bank after edge", 32'(rom_addr[20:13]), 32'h09);

        // R3: reset again restores the all-ones banks.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        reg_write(16'hD000, 8'h02);
        look(16'hA000);
        check_eq("R3", "bank1 after reset", 32'(rom_addr[20:13]), 32'h3F);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule